// File: doc/BRIEF.md
# Floppy Controller Interrupt Cause Reporter

This block owns the interrupt line of a floppy disk controller and answers the sense-interrupt-status command. Pulses from each drive are collected and held as pending causes per drive: the end of a seek or recalibrate (normal or abnormal) and a change of the drive's ready line in either direction. Two further sources also hold the interrupt high: a result-phase entry strobe, and a level request for each data byte during non-DMA execution. A sense command takes one pending cause. It returns that cause's encoded status byte and the reporting drive's present cylinder, and it drops the result-phase interrupt.

The block also screens each command opcode. An undefined opcode is rejected. So is any opcode other than a sense while a seek or recalibrate completion is still waiting to be sensed. A rejected command raises no interrupt and places the result-phase direction and request flags high with status byte 80h. A defined command that passes the screen is handed on through a one-cycle accept pulse. The command execution itself happens elsewhere.

Top module: `floppy_irq_reporter`

## Requirements
- R1: After reset, int_o, st0_o, pcn_o, rsp_valid_o, cmd_accept_o, msr_dio_o and msr_rqm_o are all 0.
- R2: A ready_chg_i pulse on drive d makes a cause pending, so that int_o is high from the cycle after the pulse. A sense reporting it returns st0 = 8'hC0 | d (bits 7:6 = 11, bit 5 = 0, bits 1:0 = drive).
- R3: A seek_done_i pulse on drive d is reported as st0 = 8'h20 | d (bits 7:6 = 00, bit 5 = 1). A seek_fail_i pulse is reported as st0 = 8'h60 | d (bits 7:6 = 01, bit 5 = 1). If both pulse together, the abnormal code is reported.
- R4: A sense command (opcode bits 4:0 = 5'h08) strobed in cycle t produces rsp_valid_o for one cycle at t+1. In that cycle st0_o is valid, and pcn_o equals the reported drive's slice of pcn_in_i (drive d at bits d*CYL_W upward). msr_dio_o and msr_rqm_o go high with every response and stay high until result_read_i.
- R5: Each sense reports exactly one cause. The lowest-numbered drive with a pending cause is reported first, and within one drive a seek cause comes before a ready cause. int_o stays high until every pending cause has been reported.
- R6: A sense with no pending cause returns st0 = 8'h80 and pcn_o = 0.
- R7: The defined opcodes (bits 4:0) are 02, 03, 04, 05, 06, 07, 08, 09, 0A, 0C, 0D, 0F, 11, 19 and 1D (hex). Any other opcode produces a response with st0 = 8'h80 and pcn_o = 0, sets msr_dio_o and msr_rqm_o, gives no cmd_accept_o and leaves int_o unchanged.
- R8: While any drive has a seek cause pending, every opcode other than a sense is rejected exactly as in R7, even if it is defined. A pending ready cause alone blocks nothing.
- R9: A defined non-sense opcode that is not blocked gives a cmd_accept_o pulse in the next cycle and no response.
- R10: result_enter_i sets a result interrupt and raises msr_dio_o and msr_rqm_o. That interrupt keeps int_o high until result_read_i or a sense command clears it.
- R11: ndma_req_i drives int_o high combinationally, in the same cycle.
- R12: If a drive event arrives in the same cycle as a sense that clears the same kind of cause on that drive, the new event stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command opcode strobe |
| cmd_op_i | input | 5 | Command opcode, low five bits |
| seek_done_i | input | NUM_DRIVES | Per-drive pulse: seek/recalibrate ended normally |
| seek_fail_i | input | NUM_DRIVES | Per-drive pulse: seek/recalibrate ended abnormally |
| ready_chg_i | input | NUM_DRIVES | Per-drive pulse: ready line changed |
| pcn_in_i | input | NUM_DRIVES*CYL_W | Present cylinder of each drive |
| result_enter_i | input | 1 | Pulse: a command entered its result phase |
| result_read_i | input | 1 | Pulse: the processor finished reading results |
| ndma_req_i | input | 1 | Level: data byte request in non-DMA execution |
| int_o | output | 1 | Interrupt line |
| st0_o | output | 8 | Status register 0 of the last response |
| pcn_o | output | CYL_W | Cylinder returned with the last response |
| rsp_valid_o | output | 1 | One-cycle pulse: st0_o and pcn_o are fresh |
| cmd_accept_o | output | 1 | One-cycle pulse: command passed the screen |
| msr_dio_o | output | 1 | Main status direction bit (result phase) |
| msr_rqm_o | output | 1 | Main status request bit (result phase) |

## Verification
A sense command that pops a cause can land in the same clock as a new event pulse for the very cause being cleared. The bench provokes this by raising the sense strobe and a ready or seek-fail pulse for the same drive on one edge. It then judges the outcome in two ways. The response must still carry the old cause, and int_o must remain high with a second sense returning the new one. The first response's code and cylinder come through the scoreboard queue, so a lost or merged event shows up as a missing or mismatched entry.

// File: rtl/floppy_irq_pkg.sv
package floppy_irq_pkg;

    localparam logic [4:0] OP_SENSE_INT = 5'h08;
    localparam logic [7:0] ST0_INVALID  = 8'h80;

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'd0,
        CAUSE_SEEK_OK  = 2'd1,
        CAUSE_SEEK_BAD = 2'd2,
        CAUSE_READY    = 2'd3
    } cause_e;

    typedef struct packed {
        logic seek_pend;
        logic seek_bad;
        logic rdy_pend;
    } slot_t;

    function automatic logic op_defined(input logic [4:0] op);
        case (op)
            5'h02, 5'h03, 5'h04, 5'h05, 5'h06, 5'h07, 5'h08, 5'h09,
            5'h0A, 5'h0C, 5'h0D, 5'h0F, 5'h11, 5'h19, 5'h1D: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] cause_to_st0(input cause_e c, input logic [1:0] drv);
        case (c)
            CAUSE_SEEK_OK:  return {2'b00, 1'b1, 3'b000, drv};
            CAUSE_SEEK_BAD: return {2'b01, 1'b1, 3'b000, drv};
            CAUSE_READY:    return {2'b11, 1'b0, 3'b000, drv};
            default:        return ST0_INVALID;
        endcase
    endfunction

endpackage

// File: rtl/irq_op_decode.sv
module irq_op_decode
    import floppy_irq_pkg::*;
(
    input  logic [4:0] op_i,
    output logic       is_sense_o,
    output logic       is_defined_o
);

    always_comb begin
        is_sense_o   = (op_i == OP_SENSE_INT);
        is_defined_o = op_defined(op_i);
    end

endmodule

// File: rtl/irq_drive_slot.sv
module irq_drive_slot
    import floppy_irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   seek_done_i,
    input  logic   seek_fail_i,
    input  logic   ready_chg_i,
    input  logic   clr_seek_i,
    input  logic   clr_ready_i,
    output logic   seek_pend_o,
    output cause_e cause_o
);

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (clr_seek_i) begin
            slot_d.seek_pend = 1'b0;
            slot_d.seek_bad  = 1'b0;
        end
        if (seek_done_i || seek_fail_i) begin
            slot_d.seek_pend = 1'b1;
            slot_d.seek_bad  = seek_fail_i;
        end
        if (clr_ready_i) slot_d.rdy_pend = 1'b0;
        if (ready_chg_i) slot_d.rdy_pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    always_comb begin
        seek_pend_o = slot_q.seek_pend;
        if (slot_q.seek_pend)     cause_o = slot_q.seek_bad ? CAUSE_SEEK_BAD : CAUSE_SEEK_OK;
        else if (slot_q.rdy_pend) cause_o = CAUSE_READY;
        else                      cause_o = CAUSE_NONE;
    end

    // R12
    seek_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seek_done_i || seek_fail_i) |=> slot_q.seek_pend);

    // R12
    ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_chg_i |=> slot_q.rdy_pend);

    // R3
    fail_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seek_fail_i |=> (cause_o == CAUSE_SEEK_BAD));

endmodule

// File: rtl/irq_cause_pick.sv
module irq_cause_pick
    import floppy_irq_pkg::*;
#(
    parameter int NUM_DRIVES = 4,
    localparam int DRV_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
    input  logic [2*NUM_DRIVES-1:0] causes_i,
    output logic                    found_o,
    output logic [DRV_W-1:0]        sel_idx_o,
    output cause_e                  sel_cause_o
);

    always_comb begin
        found_o     = 1'b0;
        sel_idx_o   = '0;
        sel_cause_o = CAUSE_NONE;
        for (int i = NUM_DRIVES - 1; i >= 0; i--) begin
            if (cause_e'(causes_i[2*i +: 2]) != CAUSE_NONE) begin
                found_o     = 1'b1;
                sel_idx_o   = DRV_W'(i);
                sel_cause_o = cause_e'(causes_i[2*i +: 2]);
            end
        end
    end

endmodule

// File: rtl/floppy_irq_reporter.sv
module floppy_irq_reporter
    import floppy_irq_pkg::*;
#(
    parameter int NUM_DRIVES = 4,
    parameter int CYL_W      = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_valid_i,
    input  logic [4:0]                  cmd_op_i,
    input  logic [NUM_DRIVES-1:0]       seek_done_i,
    input  logic [NUM_DRIVES-1:0]       seek_fail_i,
    input  logic [NUM_DRIVES-1:0]       ready_chg_i,
    input  logic [NUM_DRIVES*CYL_W-1:0] pcn_in_i,
    input  logic                        result_enter_i,
    input  logic                        result_read_i,
    input  logic                        ndma_req_i,
    output logic                        int_o,
    output logic [7:0]                  st0_o,
    output logic [CYL_W-1:0]            pcn_o,
    output logic                        rsp_valid_o,
    output logic                        cmd_accept_o,
    output logic                        msr_dio_o,
    output logic                        msr_rqm_o
);

    localparam int DRV_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1;

    typedef struct packed {
        logic [7:0]       st0;
        logic [CYL_W-1:0] pcn;
        logic             rsp;
        logic             acc;
        logic             res_phase;
        logic             res_irq;
    } rep_t;

    rep_t st_d, st_q;

    logic                    is_sense, is_def;
    logic [NUM_DRIVES-1:0]   seek_pend, cause_pend, clr_seek, clr_ready;
    cause_e                  cause_w [NUM_DRIVES];
    logic [2*NUM_DRIVES-1:0] cause_vec;
    logic                    found;
    logic [DRV_W-1:0]        sel_idx;
    cause_e                  sel_cause;
    logic                    any_seek, sense_hit;

    irq_op_decode u_dec (
        .op_i        (cmd_op_i),
        .is_sense_o  (is_sense),
        .is_defined_o(is_def)
    );

    for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_slot
        irq_drive_slot u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .seek_done_i(seek_done_i[g]),
            .seek_fail_i(seek_fail_i[g]),
            .ready_chg_i(ready_chg_i[g]),
            .clr_seek_i (clr_seek[g]),
            .clr_ready_i(clr_ready[g]),
            .seek_pend_o(seek_pend[g]),
            .cause_o    (cause_w[g])
        );
        assign cause_vec[2*g +: 2] = cause_w[g];
        assign cause_pend[g]       = (cause_w[g] != CAUSE_NONE);
    end

    irq_cause_pick #(.NUM_DRIVES(NUM_DRIVES)) u_pick (
        .causes_i   (cause_vec),
        .found_o    (found),
        .sel_idx_o  (sel_idx),
        .sel_cause_o(sel_cause)
    );

    assign any_seek = |seek_pend;

    always_comb begin
        st_d      = st_q;
        st_d.rsp  = 1'b0;
        st_d.acc  = 1'b0;
        sense_hit = 1'b0;
        if (result_read_i) begin
            st_d.res_phase = 1'b0;
            st_d.res_irq   = 1'b0;
        end
        if (cmd_valid_i) begin
            if (is_sense) begin
                st_d.rsp       = 1'b1;
                st_d.res_phase = 1'b1;
                st_d.res_irq   = 1'b0;
                if (found) begin
                    sense_hit = 1'b1;
                    st_d.st0  = cause_to_st0(sel_cause, 2'(sel_idx));
                    st_d.pcn  = pcn_in_i[int'(sel_idx)*CYL_W +: CYL_W];
                end else begin
                    st_d.st0 = ST0_INVALID;
                    st_d.pcn = '0;
                end
            end else if (!is_def || any_seek) begin
                st_d.rsp       = 1'b1;
                st_d.res_phase = 1'b1;
                st_d.st0       = ST0_INVALID;
                st_d.pcn       = '0;
            end else begin
                st_d.acc = 1'b1;
            end
        end
        if (result_enter_i) begin
            st_d.res_irq   = 1'b1;
            st_d.res_phase = 1'b1;
        end
        for (int i = 0; i < NUM_DRIVES; i++) begin
            clr_seek[i]  = sense_hit && (sel_idx == DRV_W'(i)) && (sel_cause != CAUSE_READY);
            clr_ready[i] = sense_hit && (sel_idx == DRV_W'(i)) && (sel_cause == CAUSE_READY);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign int_o        = (|cause_pend) | st_q.res_irq | ndma_req_i;
    assign st0_o        = st_q.st0;
    assign pcn_o        = st_q.pcn;
    assign rsp_valid_o  = st_q.rsp;
    assign cmd_accept_o = st_q.acc;
    assign msr_dio_o    = st_q.res_phase;
    assign msr_rqm_o    = st_q.res_phase;

    // R7
    invalid_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && !is_sense && (!is_def || any_seek))
            |=> (rsp_valid_o && st0_o == ST0_INVALID && !cmd_accept_o));

    // R9
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && is_def && !is_sense && !any_seek)
            |=> (cmd_accept_o && !rsp_valid_o));

    // R4
    rsp_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> (msr_dio_o && msr_rqm_o));

    // R6
    empty_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && is_sense && !found) |=> (st0_o == ST0_INVALID));

    // R5
    drive_num_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && is_sense && found) |=> (st0_o[1:0] == 2'($past(sel_idx))));

    // R11
    ndma_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ndma_req_i |-> int_o);

endmodule

// File: tb/floppy_irq_reporter_tb_top.sv
module floppy_irq_reporter_tb_top;

    localparam int N  = 4;
    localparam int CW = 8;
    localparam logic [4:0] OP_SNS = 5'h08;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic [4:0]      cmd_op = '0;
    logic [N-1:0]    seek_done = '0, seek_fail = '0, ready_chg = '0;
    logic [N*CW-1:0] pcn_in;
    logic            result_enter = 1'b0, result_read = 1'b0, ndma_req = 1'b0;
    logic            int_o, rsp_valid_o, cmd_accept_o, msr_dio_o, msr_rqm_o;
    logic [7:0]      st0_o;
    logic [CW-1:0]   pcn_o;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;
    logic [15:0] exp_q[$];

    always #10 clk = ~clk;

    assign pcn_in = {8'h44, 8'h33, 8'h22, 8'h11};

    floppy_irq_reporter #(.NUM_DRIVES(N), .CYL_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
        .seek_done_i(seek_done), .seek_fail_i(seek_fail), .ready_chg_i(ready_chg),
        .pcn_in_i(pcn_in), .result_enter_i(result_enter), .result_read_i(result_read),
        .ndma_req_i(ndma_req), .int_o(int_o), .st0_o(st0_o), .pcn_o(pcn_o),
        .rsp_valid_o(rsp_valid_o), .cmd_accept_o(cmd_accept_o),
        .msr_dio_o(msr_dio_o), .msr_rqm_o(msr_rqm_o)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every response
    always @(negedge clk) begin
        if (rst_n && rsp_valid_o && !done) begin
            if (exp_q.size() == 0) chk("R4", "unexpected response", 1, 0);
            else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk("R4", "response st0/pcn", int'({st0_o, pcn_o}), int'(e));
            end
        end
    end

    task automatic send(logic [4:0] op, bit rsp, logic [7:0] s0, logic [7:0] pc);
        if (rsp) exp_q.push_back({s0, pc});
        @(negedge clk); cmd_valid = 1'b1; cmd_op = op;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic evt(int kind, int drv);
        @(negedge clk);
        case (kind)
            0: seek_done[drv] = 1'b1;
            1: seek_fail[drv] = 1'b1;
            default: ready_chg[drv] = 1'b1;
        endcase
        @(negedge clk);
        seek_done = '0; seek_fail = '0; ready_chg = '0;
    endtask

    task automatic pulse_read();
        @(negedge clk); result_read = 1'b1;
        @(negedge clk); result_read = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog run did not complete actual=1 expected=0");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "int", int'(int_o), 0);
        chk("R1", "st0/pcn", int'({st0_o, pcn_o}), 0);
        chk("R1", "rsp/acc/dio/rqm", int'({rsp_valid_o, cmd_accept_o, msr_dio_o, msr_rqm_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 combinational non-DMA request
        ndma_req = 1'b1; #1;
        chk("R11", "int with ndma", int'(int_o), 1);
        ndma_req = 1'b0; #1;
        chk("R11", "int after ndma", int'(int_o), 0);

        // R2 ready change on drive 1
        evt(2, 1);
        chk("R2", "int after ready change", int'(int_o), 1);
        send(OP_SNS, 1, 8'hC1, 8'h22);
        chk("R2", "int after sense", int'(int_o), 0);
        chk("R4", "dio/rqm after sense", int'({msr_dio_o, msr_rqm_o}), 3);
        pulse_read();
        chk("R4", "dio/rqm after read", int'({msr_dio_o, msr_rqm_o}), 0);

        // R3 R5 ordering across and within drives
        @(negedge clk); seek_done[2] = 1'b1; ready_chg[2] = 1'b1; seek_fail[0] = 1'b1;
        @(negedge clk); seek_done = '0; ready_chg = '0; seek_fail = '0;
        send(OP_SNS, 1, 8'h60, 8'h11);
        send(OP_SNS, 1, 8'h22, 8'h33);
        chk("R5", "int with one left", int'(int_o), 1);
        send(OP_SNS, 1, 8'hC2, 8'h33);
        chk("R5", "int after all reported", int'(int_o), 0);
        // R3 both pulses together report abnormal
        @(negedge clk); seek_done[3] = 1'b1; seek_fail[3] = 1'b1;
        @(negedge clk); seek_done = '0; seek_fail = '0;
        send(OP_SNS, 1, 8'h63, 8'h44);
        // R6 empty sense
        send(OP_SNS, 1, 8'h80, 8'h00);

        // R7 undefined opcodes
        pulse_read();
        send(5'h01, 1, 8'h80, 8'h00);
        chk("R7", "accept on undefined", int'(cmd_accept_o), 0);
        chk("R7", "int on undefined", int'(int_o), 0);
        chk("R7", "dio/rqm on undefined", int'({msr_dio_o, msr_rqm_o}), 3);
        send(5'h1F, 1, 8'h80, 8'h00);
        chk("R7", "accept on 1F", int'(cmd_accept_o), 0);

        // R8 seek pending blocks, R9 accept
        evt(0, 3);
        send(5'h06, 1, 8'h80, 8'h00);
        chk("R8", "accept while seek pending", int'(cmd_accept_o), 0);
        chk("R8", "int kept", int'(int_o), 1);
        send(OP_SNS, 1, 8'h23, 8'h44);
        send(5'h06, 0, 8'h00, 8'h00);
        chk("R9", "accept defined", int'(cmd_accept_o), 1);
        evt(2, 0);
        send(5'h0F, 0, 8'h00, 8'h00);
        chk("R8", "ready alone does not block", int'(cmd_accept_o), 1);
        send(OP_SNS, 1, 8'hC0, 8'h11);

        // R10 result interrupt
        pulse_read();
        @(negedge clk); result_enter = 1'b1;
        @(negedge clk); result_enter = 1'b0;
        chk("R10", "int on result", int'(int_o), 1);
        chk("R10", "dio/rqm on result", int'({msr_dio_o, msr_rqm_o}), 3);
        pulse_read();
        chk("R10", "int after read", int'(int_o), 0);
        chk("R10", "dio after read", int'(msr_dio_o), 0);
        @(negedge clk); result_enter = 1'b1;
        @(negedge clk); result_enter = 1'b0;
        send(OP_SNS, 1, 8'h80, 8'h00);
        chk("R10", "int after sense clears result", int'(int_o), 0);

        // R12 same-cycle event and sense on the same cause
        evt(2, 1);
        exp_q.push_back({8'hC1, 8'h22});
        @(negedge clk); cmd_valid = 1'b1; cmd_op = OP_SNS; ready_chg[1] = 1'b1;
        @(negedge clk); cmd_valid = 1'b0; ready_chg = '0;
        chk("R12", "ready kept pending", int'(int_o), 1);
        send(OP_SNS, 1, 8'hC1, 8'h22);
        chk("R12", "int after second sense", int'(int_o), 0);
        evt(0, 1);
        exp_q.push_back({8'h21, 8'h22});
        @(negedge clk); cmd_valid = 1'b1; cmd_op = OP_SNS; seek_fail[1] = 1'b1;
        @(negedge clk); cmd_valid = 1'b0; seek_fail = '0;
        chk("R12", "seek kept pending", int'(int_o), 1);
        send(OP_SNS, 1, 8'h61, 8'h22);

        repeat (3) @(negedge clk);
        chk("R4", "responses outstanding", exp_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule